// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that lets a host read and write a small bank of 8-bit configuration registers. The host addresses the slave with a 7-bit address, which is a parameter, and then sends a command byte. The top bit of the command chooses the access type:

- **Counted block transfer.** The command is zero and the transfer always starts at register 0.
- **Indexed byte or word access.** The command's low seven bits name the register.

Reads use a repeated start followed by the address with the read bit set. A block read first returns the number of implemented registers and then the register contents.

The serial inputs pass through two synchronising flops before use. The slave pulls SDA low only through its `sdaOe` output, in open-drain fashion. The surrounding logic wires `sdaOe` to a pad that pulls the line low and feeds the resolved line back on `sdaIn`. Every register is visible on a flat output bus, so the rest of the chip can use the configuration directly.

Top module: `smbRegSlave`

## Requirements
- R1: After reset, register 0 holds 0x04, register 1 holds 0x0F and register 2 holds 0xFF, and the slave releases SDA.
- R2: The slave acknowledges a first byte whose upper seven bits equal the slave address parameter. It does not acknowledge any other address, and it leaves the registers untouched until the next start.
- R3: Byte write: the slave writes the data byte after a command with bit 7 set to the register named by command bits 6:0.
- R4: Byte read: after a command with bit 7 set, a repeated start and address+R, the slave returns the indexed register.
- R5: Word write: the slave stores the first data byte at the indexed offset and the second at the next offset.
- R6: Word read: the slave returns the indexed register and then the next one, the lower offset first.
- R7: Block write: command 0x00 is followed by a count byte, which the slave acknowledges but does not store. The slave writes the data bytes to registers 0, 1, 2 in order. A stop after any complete byte keeps the bytes already written.
- R8: Block read: after command 0x00 and a repeated start, the slave first returns the count of implemented registers, then registers from 0 upward, until the master NACKs.
- R9: Offsets at or beyond the register count read as 0x00 and ignore writes, but their command and data bytes are still acknowledged.
- R10: A start or stop seen in the middle of a byte abandons the transfer. A partial byte is never written, and a later transfer works normally.
- R11: Bits go most significant first. The slave changes SDA only while SCL is low, except when it releases SDA on a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Resolved serial data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases the line |
| regsOut | output | NUM_REGS*8 | Register contents, register i in bits 8i+7:8i |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, apart from start and stop conditions. Every SCL high or low phase lasts several system clocks longer than the synchroniser delay. The master never generates a start or stop while the slave is pulling SDA low. The bench drives the bus in quarter-bit steps of ten clocks, moves SDA only after SCL has been low for a full step, and releases SDA before every bit it expects the slave to drive. The bench resolves the shared line as a wired-AND of the two pull-down sources.

// File: rtl/smbRegPkg.sv
package smbRegPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RXACK,
    PH_TX,
    PH_TXACK
  } phase_t;

  typedef enum logic [1:0] {
    RB_ADDR,
    RB_CMD,
    RB_COUNT,
    RB_DATA
  } rxRole_t;

  // strobes from control to datapath; idx serves both write and read port
  typedef struct packed {
    logic       wrEn;
    logic [6:0] idx;
    logic [7:0] data;
  } regStrobe_t;

  function automatic logic [7:0] regResetValue(input int idx);
    case (idx)
      0:       return 8'h04;
      1:       return 8'h0F;
      2:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbRegs.sv
module smbRegs
  import smbRegPkg::*;
#(
  parameter int NUM_REGS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  output logic [7:0]            rdData,
  output logic [NUM_REGS*8-1:0] regsFlat
);

  logic [7:0] regQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ[i] <= regResetValue(i);
      else if (strb.wrEn && strb.idx == 7'(i)) regQ[i] <= strb.data;
    end
    assign regsFlat[i*8 +: 8] = regQ[i];

    // R3/R5/R7: an addressed in-range write lands in its register next cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrEn && strb.idx == 7'(i) |=> regQ[i] == $past(strb.data));
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strb.idx == 7'(i)) rdData = regQ[i];
    end
  end

  // R9: writes beyond the implemented range change nothing
  a_r9_oob_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn && int'(strb.idx) >= NUM_REGS |=> $stable(regsFlat));

endmodule

// File: rtl/smbCtrl.sv
module smbCtrl
  import smbRegPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         NUM_REGS   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output regStrobe_t strb,
  output logic       sdaOe
);

  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  logic sclMeta, sclS, sclPrev;
  logic sdaMeta, sdaS, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclMeta, sclS, sclPrev} <= 3'b111;
      {sdaMeta, sdaS, sdaPrev} <= 3'b111;
    end else begin
      sclMeta <= sclIn;  sclS <= sclMeta;  sclPrev <= sclS;
      sdaMeta <= sdaIn;  sdaS <= sdaMeta;  sdaPrev <= sdaS;
    end
  end

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;

  phase_t     phase;
  rxRole_t    role;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic [6:0] ptr;
  logic       blockMode, goTx, ackDrive, masterAck;

  logic byteDone;
  assign byteDone = (phase == PH_RX) && sclFall && (bitCnt == 4'd8);

  always_comb begin
    strb.wrEn = byteDone && (role == RB_DATA);
    strb.idx  = ptr;
    strb.data = rxShift;
  end

  assign sdaOe = (phase == PH_TX) ? !txShift[7] : ackDrive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      role      <= RB_ADDR;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= 8'hFF;
      ptr       <= '0;
      blockMode <= 1'b0;
      goTx      <= 1'b0;
      ackDrive  <= 1'b0;
      masterAck <= 1'b0;
    end else if (startDet) begin
      phase    <= PH_RX;
      role     <= RB_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      phase    <= PH_IDLE;
      ackDrive <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            rxShift <= {rxShift[6:0], sdaS};
            bitCnt  <= bitCnt + 4'd1;
          end else if (byteDone) begin
            phase    <= PH_RXACK;
            ackDrive <= 1'b1;
            goTx     <= 1'b0;
            case (role)
              RB_ADDR: begin
                if (rxShift[7:1] == SLAVE_ADDR) begin
                  goTx <= rxShift[0];
                  role <= RB_CMD;
                end else begin
                  phase    <= PH_IDLE;
                  ackDrive <= 1'b0;
                end
              end
              RB_CMD: begin
                blockMode <= !rxShift[7];
                ptr       <= rxShift[7] ? rxShift[6:0] : 7'd0;
                role      <= rxShift[7] ? RB_DATA : RB_COUNT;
              end
              RB_COUNT: role <= RB_DATA;
              default:  ptr  <= ptr + 7'd1;
            endcase
          end
        end
        PH_RXACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (goTx) begin
              phase <= PH_TX;
              if (blockMode) begin
                txShift <= COUNT_BYTE;
              end else begin
                txShift <= rdData;
                ptr     <= ptr + 7'd1;
              end
            end else begin
              phase <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              phase   <= PH_TXACK;
              txShift <= 8'hFF;
            end else begin
              txShift <= {txShift[6:0], 1'b1};
              bitCnt  <= bitCnt + 4'd1;
            end
          end
        end
        PH_TXACK: begin
          if (sclRise) masterAck <= !sdaS;
          else if (sclFall) begin
            if (masterAck) begin
              phase   <= PH_TX;
              bitCnt  <= '0;
              txShift <= rdData;
              ptr     <= ptr + 7'd1;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R11: the slave's drive never changes while SCL stays high
  a_r11_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    sclS && sclPrev |=> $stable(sdaOe));

  // R10: a stop always ends with the line released and the slave idle
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe && phase == PH_IDLE);

  // R2: a foreign address is never acknowledged
  a_r2_foreign_addr_nack: assert property (@(posedge clk) disable iff (!rstN)
    byteDone && role == RB_ADDR && rxShift[7:1] != SLAVE_ADDR |=> !sdaOe);

  // R10: a start always restarts byte reception from the address
  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> phase == PH_RX && bitCnt == 4'd0 && !sdaOe);

endmodule

// File: rtl/smbRegSlave.sv
module smbRegSlave
  import smbRegPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter int         NUM_REGS   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regsOut
);

  regStrobe_t strb;
  logic [7:0] rdData;

  smbCtrl #(.SLAVE_ADDR(SLAVE_ADDR), .NUM_REGS(NUM_REGS)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .strb(strb), .sdaOe(sdaOe)
  );

  smbRegs #(.NUM_REGS(NUM_REGS)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData), .regsFlat(regsOut)
  );

endmodule

// File: tb/smbRegSlave_tb_top.sv
module smbRegSlave_tb_top;

  localparam logic [6:0] SA   = 7'h69;
  localparam int         NREG = 3;
  localparam int         QTR  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrvLow = 1'b0;
  logic dutSdaOe;
  logic sdaLine;
  logic [NREG*8-1:0] regsOut;

  always #4 clk = ~clk;
  assign sdaLine = !(sdaDrvLow || dutSdaOe);

  smbRegSlave #(.SLAVE_ADDR(SA), .NUM_REGS(NREG)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaOe(dutSdaOe), .regsOut(regsOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0] expVal[$];
  string      expTag[$];
  logic [7:0] actVal[$];
  logic [7:0] txBytes[$];
  logic [7:0] rxExp[$];

  task automatic expectItem(input string tag, input logic [7:0] v);
    expVal.push_back(v);
    expTag.push_back(tag);
  endtask

  // monitor: compares produced results against the expected queue
  initial begin
    forever begin
      @(negedge clk);
      while (actVal.size() > 0) begin
        logic [7:0] a;
        a = actVal.pop_front();
        nChecks++;
        if (expVal.size() == 0) begin
          nFails++;
          $display("FAIL unexpected item: actual %02h expected none", a);
        end else begin
          logic [7:0] e;
          string t;
          e = expVal.pop_front();
          t = expTag.pop_front();
          if (a !== e) begin
            nFails++;
            $display("FAIL %s: actual %02h expected %02h", t, a, e);
          end
        end
      end
    end
  end

  task automatic chkRegs(input string tag, input logic [NREG*8-1:0] e);
    nChecks++;
    if (regsOut !== e) begin
      nFails++;
      $display("FAIL %s: regs actual %06h expected %06h", tag, regsOut, e);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrvLow = 1'b0; q();
    sclDrv = 1'b1;    q();
    sdaDrvLow = 1'b1; q();
    sclDrv = 1'b0;    q();
  endtask

  task automatic busStop();
    sdaDrvLow = 1'b1; q();
    sclDrv = 1'b1;    q();
    sdaDrvLow = 1'b0; q(); q();
  endtask

  task automatic sendBit(input logic b);
    sdaDrvLow = !b; q();
    sclDrv = 1'b1;  q(); q();
    sclDrv = 1'b0;  q();
  endtask

  task automatic recvBit(output logic b);
    sdaDrvLow = 1'b0; q();
    sclDrv = 1'b1;    q();
    b = sdaLine;      q();
    sclDrv = 1'b0;    q();
  endtask

  // sends a byte and pushes the observed acknowledge (1 = ACK) as a result
  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = !b;
    actVal.push_back({7'd0, ack});
  endtask

  task automatic recvByte(input logic ackIt);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recvBit(b);
      v[i] = b;
    end
    sendBit(!ackIt);
    actVal.push_back(v);
  endtask

  // write transaction: address, then every byte of txBytes
  task automatic wrTxn(input string tag, input logic [6:0] addr, input bit endStop);
    logic ack;
    expectItem(tag, {7'd0, addr == SA});
    if (addr == SA) foreach (txBytes[i]) expectItem(tag, 8'h01);
    busStart();
    sendByte({addr, 1'b0}, ack);
    if (ack) foreach (txBytes[i]) sendByte(txBytes[i], ack);
    if (endStop) busStop();
    txBytes.delete();
  endtask

  // read transaction: command, repeated start, then rxExp.size() bytes
  task automatic rdTxn(input string tag, input logic [7:0] cmd);
    logic ack;
    int n;
    n = rxExp.size();
    repeat (3) expectItem(tag, 8'h01);
    foreach (rxExp[i]) expectItem(tag, rxExp[i]);
    busStart();
    sendByte({SA, 1'b0}, ack);
    sendByte(cmd, ack);
    busStart();
    sendByte({SA, 1'b1}, ack);
    for (int i = 0; i < n; i++) recvByte(i < n - 1);
    busStop();
    rxExp.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset values
    chkRegs("R1 reset", {8'hFF, 8'h0F, 8'h04});
    nChecks++;
    if (dutSdaOe !== 1'b0) begin
      nFails++;
      $display("FAIL R1: sdaOe actual %b expected 0", dutSdaOe);
    end

    // R2: foreign address not acknowledged, registers untouched
    txBytes = '{8'h80, 8'h55};
    wrTxn("R2 foreign address", 7'h12, 1'b1);
    chkRegs("R2 no effect", {8'hFF, 8'h0F, 8'h04});

    // R3: byte write to offset 1
    txBytes = '{8'h81, 8'hA5};
    wrTxn("R3 byte write acks", SA, 1'b1);
    chkRegs("R3 byte write", {8'hFF, 8'hA5, 8'h04});

    // R4: byte reads
    rxExp = '{8'hA5};
    rdTxn("R4 byte read off1", 8'h81);
    rxExp = '{8'h04};
    rdTxn("R4 byte read off0", 8'h80);

    // R5: word write at offset 1
    txBytes = '{8'h81, 8'h3C, 8'hC3};
    wrTxn("R5 word write acks", SA, 1'b1);
    chkRegs("R5 word write", {8'hC3, 8'h3C, 8'h04});

    // R6: word read from offset 0, lower offset first
    rxExp = '{8'h04, 8'h3C};
    rdTxn("R6 word read", 8'h80);

    // R7: block write, count 3, stopped after two data bytes
    txBytes = '{8'h00, 8'h03, 8'h11, 8'h22};
    wrTxn("R7 block write acks", SA, 1'b1);
    chkRegs("R7 partial block write", {8'hC3, 8'h22, 8'h11});

    // R8/R11: block read returns count then registers 0 upward, MSB first
    rxExp = '{8'h03, 8'h11, 8'h22, 8'hC3};
    rdTxn("R8 block read", 8'h00);

    // R9: out-of-range offset acknowledged, ignored, reads zero
    txBytes = '{8'h85, 8'h77};
    wrTxn("R9 oob write acks", SA, 1'b1);
    chkRegs("R9 oob write ignored", {8'hC3, 8'h22, 8'h11});
    rxExp = '{8'h00};
    rdTxn("R9 oob read", 8'h85);
    txBytes = '{8'h82, 8'h5A, 8'h99};
    wrTxn("R9 word write crossing end", SA, 1'b1);
    chkRegs("R9 crossing end", {8'h5A, 8'h22, 8'h11});

    // R10: start in the middle of a data byte abandons it
    begin
      logic ack;
      repeat (2) expectItem("R10 abort by start acks", 8'h01);
      busStart();
      sendByte({SA, 1'b0}, ack);
      sendByte(8'h80, ack);
      for (int i = 7; i >= 4; i--) sendBit(i[0]);
      chkRegs("R10 partial byte before start", {8'h5A, 8'h22, 8'h11});
    end
    txBytes = '{8'h80, 8'h66};
    wrTxn("R10 transfer after abort", SA, 1'b1);
    chkRegs("R10 after start abort", {8'h5A, 8'h22, 8'h66});

    // R10: stop in the middle of a data byte abandons it
    begin
      logic ack;
      repeat (2) expectItem("R10 abort by stop acks", 8'h01);
      busStart();
      sendByte({SA, 1'b0}, ack);
      sendByte(8'h81, ack);
      for (int i = 0; i < 3; i++) sendBit(1'b0);
      busStop();
      chkRegs("R10 after stop abort", {8'h5A, 8'h22, 8'h66});
    end
    rxExp = '{8'h66, 8'h22};
    rdTxn("R10 read after abort", 8'h80);

    repeat (20) @(negedge clk);
    nChecks++;
    if (expVal.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard: actual %0d left expected 0", expVal.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule